// File: doc/BRIEF.md
# Timer event and status flag unit

The block is a small up-counting timer with a prescaler, a repetition counter and one channel that works either as an output compare or as an input capture. Software drives it through a simple register bus. A write-only event register lets software force single events: a counter update, a channel event, a second channel flag, a commutation flag, a trigger and a break. A status register collects the flags that hardware raises on counter events. Software clears a flag by writing 0 to its bit.

The update flag is gated in three ways. An update-disable control suppresses it. A source-restrict control limits it to counter overflow. The repetition counter allows it on only one overflow in every (repeat+1). The compare flag moves to the overflow point when the compare value is larger than the reload value. In capture mode the channel latches the counter on a chosen edge of a synchronised input pin. Reading the channel register then clears the channel flag. A synchronised trigger input can reset the counter. The interrupt output combines the enabled flags. A main output enable status is set by software and dropped by a break.

Top module: `tmr_event_unit`

## Requirements
- R1: After reset the counter, all flags, the interrupt enables, the output enable, irq and bus_rdata are 0.
- R2: Register 3 (event) reads as 0, and writing 0 to it changes nothing. Writing 1 to a bit gives exactly one event: bit0 update, bit1 channel, bit2 sets status bit2, bit5 sets status bit5, bit6 trigger, bit7 break. Register map: 0 control, 1 interrupt enable, 2 status, 3 event, 4 counter (read), 5 prescaler, 6 reload, 7 repeat, 8 channel. Control bits: 0 run, 1 update disable, 2 restrict update source, 3 capture mode, 4 falling edge, 5 both edges, 6 trigger resets counter, 7 output enable.
- R3: The update event sets the prescaler and counter to 0 and reloads the repetition counter. It sets status bit0 (update flag) only when control bits 1 and 2 are both 0.
- R4: With prescaler P, reload A and repeat R, the first update flag after an update event comes on the (R+1)(A+1)(P+1)-th clock edge that follows it.
- R5: With control bit1 set, no overflow, update event or trigger reset sets the update flag.
- R6: In compare mode the channel flag (status bit1) is set on the tick that moves the counter to the channel value C. When C is greater than the reload value, it is set on the overflow tick instead. For C=0 the match is the wrap to 0.
- R7: In capture mode, a selected edge of cap_in (rising by default, falling with control bit4, either with bit5) copies the counter into the channel register and sets status bit1. It does so on the third clock edge after the pin changes. An edge of the other polarity is ignored.
- R8: Reading register 8 clears status bit1 in capture mode only.
- R9: A capture while status bit1 is already 1 sets status bit9 (over-capture).
- R10: A rising edge on trig_in, or event bit6, sets status bit6. With control bit6 set, a trig_in edge also resets the counter as in R3.
- R11: Writing control bit7 sets or clears out_en. A break event clears out_en and sets status bit7, and it wins over a control write in the same cycle.
- R12: Writing 0 to a status bit clears it and writing 1 leaves it unchanged. A hardware set in the same cycle as a software clear keeps the flag at 1.
- R13: irq is the OR over status bits ANDed with the matching enable bits (register 1), and it comes one clock after the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | W | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | W | Read data, valid one clock after bus_rd |
| cap_in | input | 1 | Capture input pin, asynchronous |
| trig_in | input | 1 | Trigger input, asynchronous |
| irq | output | 1 | Interrupt request |
| out_en | output | 1 | Main output enable status |

## Verification
The bench sweeps prescaler, reload and repeat values and times the first update interrupt. A design that counted the repetition counter or prescaler off by one would move that edge. It sweeps compare values through 0, the reload value and values above it. A design that failed to fall back to overflow would never fire, or would fire at the wrong time. It lines up a software clear with a hardware compare match on the same edge, where a wrongly ordered priority loses the flag. It checks that reading the channel register clears the flag in capture mode but not in compare mode, and that each capture polarity ignores the other edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_IEN    = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd2;
  localparam logic [ADDR_W-1:0] A_EVGEN  = 4'd3;
  localparam logic [ADDR_W-1:0] A_COUNT  = 4'd4;
  localparam logic [ADDR_W-1:0] A_PRESC  = 4'd5;
  localparam logic [ADDR_W-1:0] A_RELOAD = 4'd6;
  localparam logic [ADDR_W-1:0] A_REPEAT = 4'd7;
  localparam logic [ADDR_W-1:0] A_CMP    = 4'd8;

  // flag positions; event bits share the low positions
  localparam int F_UPD = 0;
  localparam int F_CH1 = 1;
  localparam int F_CH2 = 2;
  localparam int F_COM = 5;
  localparam int F_TRG = 6;
  localparam int F_BRK = 7;
  localparam int F_OVC = 9;
  localparam int FLAG_W = 10;
  localparam logic [FLAG_W-1:0] FLAG_MASK = 10'b10_1110_0111;

  typedef struct packed {
    logic trig_rst;
    logic both;
    logic fall;
    logic cap_mode;
    logic urs;
    logic udis;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int OE_BIT = CTRL_W;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic sel_rise,
  input  logic sel_fall,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = (sel_rise & sync_q[STAGES-1] & ~last_q) |
                  (sel_fall & ~sync_q[STAGES-1] & last_q);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         reinit,
  input  logic [W-1:0] psc,
  input  logic [W-1:0] arr,
  input  logic [W-1:0] rep_rl,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_next,
  output logic         tick,
  output logic         ovf,
  output logic         upd_ovf
);
  logic [W-1:0] psc_q;
  logic [W-1:0] rep_q;

  assign tick     = run && !reinit && (psc_q >= psc);
  assign ovf      = tick && (cnt_q >= arr);
  assign upd_ovf  = ovf && (rep_q == '0);
  assign cnt_next = ovf ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_q <= '0;
      cnt_q <= '0;
      rep_q <= '0;
    end else if (reinit) begin
      psc_q <= '0;
      cnt_q <= '0;
      rep_q <= rep_rl;
    end else if (run) begin
      psc_q <= (psc_q >= psc) ? '0 : psc_q + 1'b1;
      if (tick) begin
        cnt_q <= cnt_next;
        if (ovf) rep_q <= upd_ovf ? rep_rl : rep_q - 1'b1;
      end
    end
  end

  // R3
  reinit_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reinit |=> (cnt_q == '0));

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && (cnt_q >= arr) && !reinit) |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_mode,
  input  logic         ic_edge,
  input  logic         cc_soft,
  input  logic         tick,
  input  logic         ovf,
  input  logic [W-1:0] cnt_q,
  input  logic [W-1:0] cnt_next,
  input  logic [W-1:0] arr,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  output logic [W-1:0] cmp_q,
  output logic         ch_set,
  output logic         cap_evt
);
  logic match;

  assign cap_evt = cap_mode && (ic_edge || cc_soft);
  assign match   = !cap_mode && tick &&
                   ((cmp_q > arr) ? ovf : (cnt_next == cmp_q));
  assign ch_set  = cap_evt || match || (!cap_mode && cc_soft);

  always_ff @(posedge clk) begin
    if (rst) cmp_q <= '0;
    else if (cap_evt) cmp_q <= cnt_q;
    else if (cmp_wr) cmp_q <= cmp_wdata;
  end

  // R7
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (cmp_q == $past(cnt_q)));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [W-1:0]      rdata,
  output ctrl_t             ctrl,
  output logic [W-1:0]      psc,
  output logic [W-1:0]      arr,
  output logic [W-1:0]      rep_rl,
  output logic              cmp_wr,
  output logic              ev_ug,
  output logic              ev_cc1,
  output logic              ev_cc2,
  output logic              ev_com,
  output logic              ev_trg,
  output logic              ev_brk,
  input  logic              upd_set,
  input  logic              ch_set,
  input  logic              trg_hw,
  input  logic              cap_evt,
  input  logic [W-1:0]      cnt_q,
  input  logic [W-1:0]      cmp_q,
  output logic              moe,
  output logic              irq
);
  logic [FLAG_W-1:0] stat_q, ien_q, set_v, keep_v;
  logic [W-1:0]      rd_mux;
  logic              ev_wr;

  assign ev_wr  = wr && (addr == A_EVGEN);
  assign ev_ug  = ev_wr && wdata[F_UPD];
  assign ev_cc1 = ev_wr && wdata[F_CH1];
  assign ev_cc2 = ev_wr && wdata[F_CH2];
  assign ev_com = ev_wr && wdata[F_COM];
  assign ev_trg = ev_wr && wdata[F_TRG];
  assign ev_brk = ev_wr && wdata[F_BRK];
  assign cmp_wr = wr && (addr == A_CMP);

  always_comb begin
    set_v        = '0;
    set_v[F_UPD] = upd_set;
    set_v[F_CH1] = ch_set;
    set_v[F_CH2] = ev_cc2;
    set_v[F_COM] = ev_com;
    set_v[F_TRG] = ev_trg | trg_hw;
    set_v[F_BRK] = ev_brk;
    set_v[F_OVC] = cap_evt & stat_q[F_CH1];
  end

  always_comb begin
    keep_v = '1;
    if (wr && (addr == A_STAT)) keep_v = wdata[FLAG_W-1:0];
    if (rd && (addr == A_CMP) && ctrl.cap_mode) keep_v[F_CH1] = 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL:   rd_mux[OE_BIT:0] = {moe, ctrl};
      A_IEN:    rd_mux[FLAG_W-1:0] = ien_q;
      A_STAT:   rd_mux[FLAG_W-1:0] = stat_q;
      A_COUNT:  rd_mux = cnt_q;
      A_PRESC:  rd_mux = psc;
      A_RELOAD: rd_mux = arr;
      A_REPEAT: rd_mux = rep_rl;
      A_CMP:    rd_mux = cmp_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      moe    <= 1'b0;
      ien_q  <= '0;
      psc    <= '0;
      arr    <= '0;
      rep_rl <= '0;
      stat_q <= '0;
      irq    <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr && (addr == A_CTRL)) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (ev_brk) moe <= 1'b0;
      else if (wr && (addr == A_CTRL)) moe <= wdata[OE_BIT];
      if (wr && (addr == A_IEN)) ien_q <= wdata[FLAG_W-1:0] & FLAG_MASK;
      if (wr && (addr == A_PRESC)) psc <= wdata;
      if (wr && (addr == A_RELOAD)) arr <= wdata;
      if (wr && (addr == A_REPEAT)) rep_rl <= wdata;
      stat_q <= ((stat_q & keep_v) | set_v) & FLAG_MASK;
      irq    <= |(stat_q & ien_q);
      if (rd) rdata <= rd_mux;
    end
  end

  // R11
  brk_clears_oe_chk: assert property (@(posedge clk) disable iff (rst)
    ev_brk |=> (!moe && stat_q[F_BRK]));

  // R12
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_v[F_CH1] |=> stat_q[F_CH1]);

  // R2
  evgen_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && (addr == A_EVGEN)) |=> (rdata == '0));

  // R9
  overcap_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && stat_q[F_CH1]) |=> stat_q[F_OVC]);
endmodule

// File: rtl/tmr_event_unit.sv
module tmr_event_unit
  import tmr_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [W-1:0]      bus_rdata,
  input  logic              cap_in,
  input  logic              trig_in,
  output logic              irq,
  output logic              out_en
);
  ctrl_t        ctrl;
  logic [W-1:0] psc, arr, rep_rl, cnt_q, cnt_next, cmp_q;
  logic         cmp_wr, ev_ug, ev_cc1, ev_cc2, ev_com, ev_trg, ev_brk;
  logic         tick, ovf, upd_ovf, reinit, upd_set;
  logic         ch_set, cap_evt, ic_edge, trig_edge;

  tmr_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .wr(bus_wr),
    .rd(bus_rd), .rdata(bus_rdata), .ctrl(ctrl), .psc(psc), .arr(arr),
    .rep_rl(rep_rl), .cmp_wr(cmp_wr), .ev_ug(ev_ug), .ev_cc1(ev_cc1),
    .ev_cc2(ev_cc2), .ev_com(ev_com), .ev_trg(ev_trg), .ev_brk(ev_brk),
    .upd_set(upd_set), .ch_set(ch_set), .trg_hw(trig_edge),
    .cap_evt(cap_evt), .cnt_q(cnt_q), .cmp_q(cmp_q), .moe(out_en), .irq(irq)
  );

  tmr_edge #(.STAGES(SYNC_STAGES)) u_ic_edge (
    .clk(clk), .rst(rst), .din(cap_in),
    .sel_rise(!ctrl.fall || ctrl.both), .sel_fall(ctrl.fall || ctrl.both),
    .edge_o(ic_edge)
  );

  tmr_edge #(.STAGES(SYNC_STAGES)) u_trig_edge (
    .clk(clk), .rst(rst), .din(trig_in),
    .sel_rise(1'b1), .sel_fall(1'b0), .edge_o(trig_edge)
  );

  assign reinit  = ev_ug || (trig_edge && ctrl.trig_rst);
  assign upd_set = !ctrl.udis && (upd_ovf || (reinit && !ctrl.urs));

  tmr_count #(.W(W)) u_count (
    .clk(clk), .rst(rst), .run(ctrl.run), .reinit(reinit), .psc(psc),
    .arr(arr), .rep_rl(rep_rl), .cnt_q(cnt_q), .cnt_next(cnt_next),
    .tick(tick), .ovf(ovf), .upd_ovf(upd_ovf)
  );

  tmr_chan #(.W(W)) u_chan (
    .clk(clk), .rst(rst), .cap_mode(ctrl.cap_mode), .ic_edge(ic_edge),
    .cc_soft(ev_cc1), .tick(tick), .ovf(ovf), .cnt_q(cnt_q),
    .cnt_next(cnt_next), .arr(arr), .cmp_wr(cmp_wr), .cmp_wdata(bus_wdata),
    .cmp_q(cmp_q), .ch_set(ch_set), .cap_evt(cap_evt)
  );

  // R5
  no_upd_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.udis && !(bus_wr && bus_addr == A_STAT) && !u_regs.stat_q[F_UPD])
      |=> !u_regs.stat_q[F_UPD]);
endmodule

// File: tb/tb_tmr_event_unit.sv
module tb_tmr_event_unit;
  localparam int W = 16;
  localparam logic [3:0] CTRL = 0, IEN = 1, STAT = 2, EVG = 3, CNT = 4,
                         PRESC = 5, RELOAD = 6, REPEAT = 7, CMP = 8;
  localparam logic [15:0] RUN = 16'h1, UDIS = 16'h2, URS = 16'h4, CAP = 16'h8,
                          FALL = 16'h10, TRST = 16'h40, OE = 16'h80;

  logic clk = 0, rst = 1;
  logic [3:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, bus_rdata;
  logic bus_wr = 0, bus_rd = 0, cap_in = 0, trig_in = 0, irq, out_en;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_event_unit #(.W(W)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cap_in(cap_in), .trig_in(trig_in), .irq(irq), .out_en(out_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic br(input logic [3:0] a, output int d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    @(posedge clk); #1;
    bus_rd = 0;
    d = int'(bus_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_irq(input int limit, output int k);
    int i = 0;
    k = 0;
    while (k == 0 && i < limit) begin
      @(posedge clk); #1;
      i++;
      if (irq) k = i;
    end
  endtask

  task automatic setup(input logic [15:0] c, input int p, input int a, input int r);
    bw(CTRL, c & ~RUN);
    bw(STAT, 16'h0);
    bw(PRESC, 16'(p));
    bw(RELOAD, 16'(a));
    bw(REPEAT, 16'(r));
    bw(CTRL, c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int d, k, exp;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    chk("R1 out_en", int'(out_en), 0);
    chk("R1 rdata", int'(bus_rdata), 0);
    br(CNT, d);  chk("R1 count", d, 0);
    br(STAT, d); chk("R1 status", d, 0);
    br(IEN, d);  chk("R1 enables", d, 0);

    // R2 event register
    bw(EVG, 16'h24);
    br(STAT, d); chk("R2 cc2+com flags", d, 16'h24);
    br(EVG, d);  chk("R2 event reads zero", d, 0);
    bw(EVG, 16'h0);
    br(STAT, d); chk("R2 zero write no effect", d, 16'h24);
    // R12 write 1 keeps, write 0 clears
    bw(STAT, 16'hFFFF);
    br(STAT, d); chk("R12 write ones keep", d, 16'h24);
    bw(STAT, 16'hFFDF);
    br(STAT, d); chk("R12 clear one bit", d, 16'h04);
    bw(STAT, 16'h0);
    br(STAT, d); chk("R12 clear all", d, 0);

    // R11 output enable and break
    bw(CTRL, OE);
    chk("R11 oe set", int'(out_en), 1);
    bw(EVG, 16'h80);
    chk("R11 break clears oe", int'(out_en), 0);
    br(STAT, d); chk("R11 break flag", d, 16'h80);
    bw(STAT, 0);

    // R4 update timing sweep
    bw(IEN, 16'h1);
    for (int p = 0; p < 2; p++)
      for (int ai = 0; ai < 3; ai++)
        for (int r = 0; r < 3; r++) begin
          setup(RUN | URS, p, 1 << ai, r);
          bw(EVG, 16'h1);
          wait_irq(200, k);
          exp = (r + 1) * ((1 << ai) + 1) * (p + 1) + 1;
          chk($sformatf("R4 p%0d a%0d r%0d", p, 1 << ai, r), k, exp);
        end

    // R3 update event sets flag when not restricted
    setup(RUN, 0, 100, 0);
    bw(EVG, 16'h1);
    wait_irq(5, k); chk("R3 update event flag", k, 1);
    br(CNT, d); chk("R3 counter restarted", (d < 5) ? 1 : 0, 1);
    // R5 update disabled
    setup(RUN | UDIS, 0, 3, 0);
    bw(EVG, 16'h1);
    wait_irq(60, k); chk("R5 no update flag", k, 0);

    // R6 compare sweep
    bw(IEN, 16'h2);
    for (int c = 0; c < 12; c++) begin
      setup(RUN | URS, 0, 9, 0);
      bw(CMP, 16'(c));
      bw(EVG, 16'h1);
      wait_irq(40, k);
      exp = (c == 0 || c > 9) ? 11 : c + 1;
      chk($sformatf("R6 compare %0d", c), k, exp);
    end

    // R12 hardware set wins over clear in same cycle
    bw(IEN, 16'h0);
    setup(RUN | URS, 0, 9, 0);
    bw(CMP, 16'd1);
    bw(EVG, 16'h1);
    bw(STAT, 16'h0);
    br(STAT, d); chk("R12 hw set wins", d & 2, 2);

    // R8 compare mode read does not clear
    setup(URS, 0, 9, 0);
    bw(EVG, 16'h2);
    br(CMP, d);
    br(STAT, d); chk("R8 compare read keeps flag", d & 2, 2);

    // R7 capture
    setup(RUN | URS | CAP, 0, 1000, 0);
    bw(EVG, 16'h1);
    idle(7);
    bw(CTRL, URS | CAP);
    br(CNT, k);
    bw(STAT, 0);
    @(negedge clk); cap_in = 1;
    idle(5);
    br(STAT, d); chk("R7 capture flag", d, 16'h2);
    br(CMP, d);  chk("R7 captured value", d, k);
    br(STAT, d); chk("R8 capture read clears", d, 0);
    @(negedge clk); cap_in = 0;
    idle(5);
    br(STAT, d); chk("R7 falling ignored", d, 0);
    bw(CTRL, URS | CAP | FALL);
    @(negedge clk); cap_in = 1;
    idle(5);
    br(STAT, d); chk("R7 rising ignored in fall mode", d, 0);
    @(negedge clk); cap_in = 0;
    idle(5);
    br(STAT, d); chk("R7 fall capture", d, 16'h2);
    // R9 over-capture
    @(negedge clk); cap_in = 1;
    idle(5);
    @(negedge clk); cap_in = 0;
    idle(5);
    br(STAT, d); chk("R9 over-capture", d, 16'h202);

    // R10 trigger
    setup(RUN | TRST, 0, 1000, 0);
    idle(4);
    bw(CTRL, TRST);
    bw(STAT, 0);
    br(CNT, d); chk("R10 counter nonzero before", (d > 0) ? 1 : 0, 1);
    @(negedge clk); trig_in = 1;
    idle(5);
    @(negedge clk); trig_in = 0;
    br(CNT, d);  chk("R10 trigger resets counter", d, 0);
    br(STAT, d); chk("R10 trigger and update flags", d, 16'h41);
    bw(CTRL, TRST | UDIS);
    bw(STAT, 0);
    @(negedge clk); trig_in = 1;
    idle(5);
    @(negedge clk); trig_in = 0;
    br(STAT, d); chk("R5 trigger with update disabled", d, 16'h40);
    bw(STAT, 0);
    bw(EVG, 16'h40);
    br(STAT, d); chk("R10 soft trigger", d, 16'h40);

    // R13 interrupt combine
    bw(STAT, 0);
    bw(IEN, 16'h80);
    idle(2);
    chk("R13 irq low", int'(irq), 0);
    bw(EVG, 16'h80);
    chk("R13 irq not same cycle", int'(irq), 0);
    idle(1);
    chk("R13 irq one cycle later", int'(irq), 1);
    bw(IEN, 16'h40);
    idle(2);
    chk("R13 irq masked", int'(irq), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule